// File: doc/BRIEF.md
# GPIO Bank with Latched Interrupts

This block is a bank of up to 32 general-purpose pins behind a small word-addressed register port. Writes take effect on the clock edge that samples `reg_wr`. A read issued with `reg_rd` returns its word on `reg_rdata` one cycle later. The port has no back-pressure: every strobe completes in one cycle, and `reg_rdata` holds its last value until the next read. Software sets the drive value and the drive enable of each pin. It can also read the pin levels, which pass through a synchroniser first.

Each pin can raise an interrupt on either an edge or a level. Its trigger-mode bit picks edge or level, and its polarity bit picks rising/high or falling/low. When a pin's condition is seen, a sticky pending bit is set. A level condition is latched in the same way as an edge. A pin reacts to one edge direction only. To catch both edges, software flips the polarity after each event. The pending bits are masked by the enable bits, and any bit left is ORed into a single request line. Software clears pending bits by writing ones to the acknowledge register.

Top module: `gpio_irq_bank`

## Requirements
- R1: Reset (active-high `rst`) clears the drive value, the drive enable, the interrupt enables and all pending bits. Trigger mode and polarity reset to all ones, which selects rising-edge detection. Pins that are high while reset is held do not raise an event once reset ends.
- R2: Register addresses are: 0 drive value, 1 drive enable, 2 pin levels, 3 trigger mode, 4 polarity, 5 interrupt enable, 6 acknowledge, 7 pending. Writing address 0 or 1 updates `pin_out` or `pin_oe` on the next edge, and a read returns the value last written.
- R3: Reading address 2 returns each pin's level after a two-flop synchroniser, whatever the drive enable is set to.
- R4: With trigger bit = 1 (edge), a pin with polarity 1 sets its pending bit on a 0-to-1 change only. A pin with polarity 0 sets it on a 1-to-0 change only.
- R5: With trigger bit = 0 (level), the pending bit is set while the synchronised level equals the polarity bit. It stays set after the level goes away until software acknowledges it.
- R6: Writing address 6 clears every pending bit written as 1. Bits written as 0, and all other pending bits, are left unchanged.
- R7: When a new event and an acknowledge of the same pin fall in the same cycle, the pin stays pending.
- R8: `irq` is high exactly when some pending bit has its enable bit (address 5) set. Pending bits still latch for pins that are not enabled.
- R9: Bits at or above NPINS read as zero and ignore writes. Address 6 always reads as zero.
- R10: `reg_rdata` changes only in the cycle after a `reg_rd` strobe. Otherwise it keeps the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| pin_in | input | NPINS | Raw pin levels, asynchronous |
| pin_out | output | NPINS | Drive value per pin |
| pin_oe | output | NPINS | Drive enable per pin, 1 drives |
| irq | output | 1 | Summary interrupt request |

## Verification
The assertions assume reset is held from time zero. They also assume that pending bits change only through detected events or acknowledge writes. `pin_in` is the only asynchronous input, and the synchroniser and the warm-up window after reset absorb its changes. The stimulus drives strobes and pin levels on the falling clock edge. It holds every pin pulse for at least two cycles so that the synchroniser captures it. Before it reconfigures trigger mode or polarity, it parks the pins at known levels and then acknowledges everything, so that each expected pending value follows only from the requirement being tested.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] REG_DOUT = 3'd0;
  localparam logic [REG_ADDR_W-1:0] REG_DIR  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] REG_PINS = 3'd2;
  localparam logic [REG_ADDR_W-1:0] REG_TRIG = 3'd3;
  localparam logic [REG_ADDR_W-1:0] REG_POL  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] REG_IEN  = 3'd5;
  localparam logic [REG_ADDR_W-1:0] REG_ACK  = 3'd6;
  localparam logic [REG_ADDR_W-1:0] REG_PEND = 3'd7;

  // condition seen on one pin for the given mode and polarity
  function automatic logic pin_hit(input logic edge_mode, input logic pol_hi,
                                   input logic now_lvl, input logic old_lvl);
    if (edge_mode)
      return pol_hi ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
    else
      return ~(now_lvl ^ pol_hi);
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
`timescale 1ns/1ps
module gpio_bank_detect import gpio_bank_pkg::*; #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] trig_edge,
  input  logic [W-1:0] pol_hi,
  input  logic [W-1:0] ack,
  output logic [W-1:0] ev,
  output logic [W-1:0] pend
);
  // cycles until the previous-sample register holds real pin data
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [CW-1:0] warm_q;
  logic          primed;
  logic [W-1:0]  prev_q;
  logic [W-1:0]  hit;
  logic [W-1:0]  pend_q;

  always_ff @(posedge clk) begin
    if (rst)                       warm_q <= '0;
    else if (warm_q != CW'(WARM))  warm_q <= warm_q + 1'b1;
  end
  assign primed = (warm_q == CW'(WARM));

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign hit[i] = pin_hit(trig_edge[i], pol_hi[i], lvl[i], prev_q[i]);
    end
  endgenerate

  assign ev = primed ? hit : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= (pend_q & ~ack) | ev;   // a fresh event outranks the clear
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs import gpio_bank_pkg::*; #(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NPINS-1:0]      pins_sync,
  input  logic [NPINS-1:0]      pend,
  output logic [NPINS-1:0]      dout,
  output logic [NPINS-1:0]      dir,
  output logic [NPINS-1:0]      trig_edge,
  output logic [NPINS-1:0]      pol_hi,
  output logic [NPINS-1:0]      ien,
  output logic [NPINS-1:0]      ack
);
  logic [NPINS-1:0]  wbits;
  logic [DATA_W-1:0] unused_wdata;
  logic [NPINS-1:0]  sel_bits;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;

  assign wbits        = reg_wdata[NPINS-1:0];
  assign unused_wdata = reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      dir       <= '0;
      trig_edge <= '1;
      pol_hi    <= '1;
      ien       <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        REG_DOUT: dout      <= wbits;
        REG_DIR:  dir       <= wbits;
        REG_TRIG: trig_edge <= wbits;
        REG_POL:  pol_hi    <= wbits;
        REG_IEN:  ien       <= wbits;
        default:  ;
      endcase
    end
  end

  assign ack = (reg_wr && reg_addr == REG_ACK) ? wbits : '0;

  always_comb begin
    case (reg_addr)
      REG_DOUT: sel_bits = dout;
      REG_DIR:  sel_bits = dir;
      REG_PINS: sel_bits = pins_sync;
      REG_TRIG: sel_bits = trig_edge;
      REG_POL:  sel_bits = pol_hi;
      REG_IEN:  sel_bits = ien;
      REG_PEND: sel_bits = pend;
      default:  sel_bits = '0;
    endcase
    rd_word               = '0;
    rd_word[NPINS-1:0]    = sel_bits;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_word;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank import gpio_bank_pkg::*; #(
  parameter int NPINS       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic                  irq
);
  logic [NPINS-1:0] lvl_w;
  logic [NPINS-1:0] trig_w;
  logic [NPINS-1:0] pol_w;
  logic [NPINS-1:0] ien_w;
  logic [NPINS-1:0] clr_w;
  logic [NPINS-1:0] ev_w;
  logic [NPINS-1:0] pend_w;

  gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl_w)
  );

  gpio_bank_regs #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pins_sync (lvl_w),
    .pend      (pend_w),
    .dout      (pin_out),
    .dir       (pin_oe),
    .trig_edge (trig_w),
    .pol_hi    (pol_w),
    .ien       (ien_w),
    .ack       (clr_w)
  );

  gpio_bank_detect #(.W(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .lvl       (lvl_w),
    .trig_edge (trig_w),
    .pol_hi    (pol_w),
    .ack       (clr_w),
    .ev        (ev_w),
    .pend      (pend_w)
  );

  assign irq = |(pend_w & ien_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk #(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  ev,
  input logic [NPINS-1:0]  clr
);
  localparam logic [DATA_W-1:0] PIN_MASK = {DATA_W{1'b1}} >> (DATA_W - NPINS);

  // R1
  oe_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0));

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(pend) & ~$past(clr)) & ~pend) == '0));

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(ev) & ~pend) == '0));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend != '0));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((reg_rdata & ~PIN_MASK) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rdata (reg_rdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .pend      (pend_w),
  .ev        (ev_w),
  .clr       (clr_w)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int NP = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NP-1:0] pin_in = '1;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] v;
    logic [NP-1:0] trig, pol, bitp, exp1, exp2;
    logic          en;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared right after reset
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 irq", irq, 0);
    settle();
    rd(3'd0, v); check("R1 dout", v, 0);
    rd(3'd1, v); check("R1 dir", v, 0);
    rd(3'd5, v); check("R1 ien", v, 0);
    rd(3'd7, v); check("R1 pend after high pins in reset", v, 0);

    // R4: falling edges ignored under the reset rising mode
    pin_in = '0; settle();
    rd(3'd7, v); check("R4 falling ignored", v, 0);

    // R2 and R9: readback, pins, upper bits
    wr(3'd0, 8'h5A);
    rd(3'd0, v); check("R2 R9 dout readback", v, 8'h0A);
    check("R2 pin_out", pin_out, 4'hA);
    wr(3'd1, 8'hF3);
    rd(3'd1, v); check("R2 R9 dir readback", v, 8'h03);
    check("R2 pin_oe", pin_oe, 4'h3);
    rd(3'd6, v); check("R9 ack reads zero", v, 0);

    // R3 and R4: levels independent of drive enable; rising edges latch
    pin_in = 4'b1001; settle();
    rd(3'd2, v); check("R3 pin levels", v, 8'h09);
    rd(3'd7, v); check("R4 rising latched", v, 8'h09);
    check("R8 no irq while disabled", irq, 0);
    // R6: partial clears
    wr(3'd6, 8'h01);
    rd(3'd7, v); check("R6 clear one bit", v, 8'h08);
    wr(3'd6, 8'h00);
    rd(3'd7, v); check("R6 zero write no effect", v, 8'h08);
    // R8: mask behaviour
    wr(3'd5, 8'h08); check("R8 irq enabled", irq, 1);
    wr(3'd5, 8'h01); check("R8 irq masked", irq, 0);
    wr(3'd6, 8'hFF);
    rd(3'd7, v); check("R6 clear all", v, 0);
    pin_in = '0; settle();
    rd(3'd2, v); check("R3 pin levels low", v, 0);

    // R7: event in the same cycle as its clear
    pin_in = 4'b0001; settle();
    pin_in = 4'b0000; settle();
    rd(3'd7, v); check("R7 setup pending", v, 8'h01);
    pin_in = 4'b0001;
    @(negedge clk);
    wr(3'd6, 8'h01);
    settle();
    rd(3'd7, v); check("R7 event wins over clear", v, 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd7, v); check("R7 later clear works", v, 0);

    // R5: level latch and re-latch
    pin_in = '0; settle();
    wr(3'd3, 8'h0E); wr(3'd4, 8'h0F); wr(3'd6, 8'h0F);
    rd(3'd7, v); check("R5 no level yet", v, 0);
    pin_in = 4'b0001; repeat (2) @(negedge clk);
    pin_in = 4'b0000; settle();
    rd(3'd7, v); check("R5 pulse latched", v, 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd7, v); check("R5 cleared after level gone", v, 0);
    pin_in = 4'b0001; settle();
    wr(3'd6, 8'h01);
    rd(3'd7, v); check("R5 relatch while level held", v, 8'h01);
    pin_in = '0; settle();
    wr(3'd3, 8'h0F); wr(3'd6, 8'h0F);

    // Sweep: pin x mode x polarity x start level
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int pl = 0; pl < 2; pl++) begin
          for (int l0 = 0; l0 < 2; l0++) begin
            bitp = NP'(1) << p;
            wr(3'd3, 8'h0F); wr(3'd4, 8'h0F); wr(3'd5, 8'h00);
            pin_in = l0[0] ? bitp : '0; settle();
            trig = 4'hF; trig[p] = m[0];
            pol  = 4'hF; pol[p]  = pl[0];
            wr(3'd3, {4'h0, trig}); wr(3'd4, {4'h0, pol}); wr(3'd6, 8'h0F);
            settle();
            exp1 = (m == 0 && l0 == pl) ? bitp : '0;
            rd(3'd7, v); check("R5 R4 sweep before toggle", v, {4'h0, exp1});
            en = ((p + m + pl) % 2) == 1;
            wr(3'd5, en ? {4'h0, bitp} : 8'h00);
            check("R8 sweep irq before toggle", irq, (exp1 != 0) && en);
            pin_in = l0[0] ? '0 : bitp; settle();
            if (m == 1) exp2 = ((1 - l0) == pl) ? bitp : '0;
            else        exp2 = bitp;
            rd(3'd7, v); check("R4 R5 sweep after toggle", v, {4'h0, exp2});
            check("R8 sweep irq after toggle", irq, (exp2 != 0) && en);
            pin_in = '0; settle();
          end
        end
      end
    end

    // R10: read data holds between reads
    wr(3'd3, 8'h0F); wr(3'd4, 8'h0F); wr(3'd5, 8'h00); wr(3'd6, 8'h0F);
    rd(3'd7, v); check("R10 pend read", v, 0);
    pin_in = 4'b0010; settle();
    check("R10 rdata held", reg_rdata, 0);
    rd(3'd7, v); check("R10 fresh read", v, 8'h02);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule